// File: doc/BRIEF.md
# Interrupt Acknowledge Priority Arbiter

This block decides which interrupt source answers an interrupt acknowledge cycle. Several modules can hold a pending request at a level from 1 to 7. Each module also owns a 4-bit arbitration ID that can be reprogrammed. Module 0 is the integration module. Its request is built from three local sources: a periodic timer, the external request pins and an edge-detect port. The other modules each present one pending level.

When the processor opens an acknowledge cycle at some level, the block collects the modules requesting at exactly that level. A module with ID zero never takes part. Among the rest, the highest ID wins. The block captures a one-hot module grant and, when module 0 wins, a one-hot choice of its local source. Both are held until the cycle closes. If nobody contends, the block raises a flag so the cycle can be ended by bus error. A separate flag reports when two modules share the same non-zero ID.

Top module: `iack_arbiter`

## Requirements
- R1: After reset, grant and local-source outputs are zero and `no_taker` and `cfg_err` are low. Module 0's ID is 4'hF and every other module's ID is 4'h0.
- R2: Arbitration is performed on every acknowledge cycle, so a single requesting module with a non-zero ID is granted.
- R3: Only modules whose pending level equals `ack_lvl` contend. Level 0 means no request, and an acknowledge at level 0 has no contender.
- R4: A module whose ID is 4'h0 never contends, even with a pending request at the acknowledged level.
- R5: Among contenders, the highest ID wins. `grant` is one-hot, with bit i standing for module i.
- R6: A timer level field of 3'b000 disables the timer request, even when `tmr_req` is high.
- R7: Within module 0 at the acknowledged level, the timer beats the pins and the pins beat edge-detect. `home_src` bit 0 is timer, bit 1 is pins, bit 2 is edge-detect, and it is non-zero only when module 0 is granted.
- R8: When no module contends, `no_taker` is high and `grant` is zero for the whole cycle.
- R9: `cfg_err` is high while two modules share the same non-zero ID; equal zero IDs are not an error. Under a tie the grant stays one-hot, going to the lowest-numbered tied module.
- R10: Outputs are captured on the cycle after `ack_start` while idle. They hold until `ack_done`, and further `ack_start` pulses or request changes do not affect them. After `ack_done` they return to zero.
- R11: A clock edge with `id_wr_en` high loads `id_wr_val` into the ID of module `id_wr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_wr_en | input | 1 | Write enable for an arbitration ID |
| id_wr_sel | input | MOD_W | Module whose ID is written |
| id_wr_val | input | 4 | New ID value |
| tmr_req | input | 1 | Periodic timer request pending |
| tmr_lvl | input | 3 | Timer priority field, 0 disables |
| pin_lvl | input | 3 | External pin request level, 0 none |
| edg_lvl | input | 3 | Edge-detect request level, 0 none |
| peer_lvl | input | 3*(N_MOD-1) | Pending levels of modules 1..N_MOD-1, module i at bits 3(i-1)+:3 |
| ack_start | input | 1 | Acknowledge cycle opens |
| ack_lvl | input | 3 | Level being acknowledged |
| ack_done | input | 1 | Acknowledge cycle closes |
| grant | output | N_MOD | One-hot winning module |
| home_src | output | 3 | One-hot winning local source of module 0 |
| no_taker | output | 1 | No contender: end the cycle by bus error |
| cfg_err | output | 1 | Duplicate non-zero IDs programmed |

## Verification
The first patterns use distinct IDs. They cover a lone requester, two and three contenders at one level, and contenders split across levels. Together these separate "highest ID wins" from "first index wins" and from "any level matches". Module 0 patterns stack the timer, pins and edge-detect at one level and then remove them one at a time. Module 0 is also made to lose to a peer with a higher ID, which shows that the local choice is hidden unless module 0 wins. Further patterns cover an ID of zero, a timer field of zero with an acknowledge at level 0, duplicate IDs, and request changes and extra start pulses during a held cycle.

// File: rtl/iarb_pkg.sv
package iarb_pkg;
  localparam int LVL_W = 3;
  localparam int ID_W  = 4;
  localparam int N_LOC = 3;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [ID_W-1:0]  arb_id_t;

  localparam arb_id_t HOME_ID_RST = 4'hF;
  localparam arb_id_t PEER_ID_RST = 4'h0;

  localparam int LOC_TMR = 0;
  localparam int LOC_PIN = 1;
  localparam int LOC_EDG = 2;
endpackage

// File: rtl/iarb_id_bank.sv
module iarb_id_bank
  import iarb_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int MOD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MOD_W-1:0] wr_sel,
  input  arb_id_t          wr_id,
  output arb_id_t          ids [N_MOD],
  output logic             dup_err
);

  for (genvar g = 0; g < N_MOD; g++) begin : g_id
    localparam arb_id_t RST_VAL = (g == 0) ? HOME_ID_RST : PEER_ID_RST;
    logic    id_en;
    arb_id_t id_d;
    arb_id_t id_q;

    always_comb begin
      id_en = wr_en && (wr_sel == MOD_W'(g));
      id_d  = wr_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     id_q <= RST_VAL;
      else if (id_en) id_q <= id_d;
    end

    assign ids[g] = id_q;

    AST_ID_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == MOD_W'(g)) |=> id_q == $past(wr_id)); // R11
  end

  always_comb begin
    dup_err = 1'b0;
    for (int i = 0; i < N_MOD; i++) begin
      for (int j = i + 1; j < N_MOD; j++) begin
        if (ids[i] == ids[j] && ids[i] != '0) dup_err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/iarb_home_src.sv
module iarb_home_src
  import iarb_pkg::*;
(
  input  logic             tmr_req,
  input  lvl_t             tmr_lvl,
  input  lvl_t             pin_lvl,
  input  lvl_t             edg_lvl,
  input  lvl_t             ack_lvl,
  output logic             home_hit,
  output logic [N_LOC-1:0] loc_sel
);

  logic tmr_hit, pin_hit, edg_hit;

  always_comb begin
    tmr_hit = tmr_req && (tmr_lvl != '0) && (tmr_lvl == ack_lvl);
    pin_hit = (pin_lvl != '0) && (pin_lvl == ack_lvl);
    edg_hit = (edg_lvl != '0) && (edg_lvl == ack_lvl);

    loc_sel = '0;
    if (tmr_hit)      loc_sel[LOC_TMR] = 1'b1;
    else if (pin_hit) loc_sel[LOC_PIN] = 1'b1;
    else if (edg_hit) loc_sel[LOC_EDG] = 1'b1;

    home_hit = tmr_hit || pin_hit || edg_hit;
  end

endmodule

// File: rtl/iarb_pick.sv
module iarb_pick
  import iarb_pkg::*;
#(
  parameter int N_MOD = 4
) (
  input  logic [N_MOD-1:0] contend,
  input  arb_id_t          ids [N_MOD],
  output logic [N_MOD-1:0] win,
  output logic             any
);

  arb_id_t best;
  int      sel;

  always_comb begin
    best = '0;
    sel  = 0;
    for (int i = 0; i < N_MOD; i++) begin
      if (contend[i] && ids[i] > best) begin
        best = ids[i];
        sel  = i;
      end
    end
    any = |contend;
    win = '0;
    if (any) win[sel] = 1'b1;
  end

endmodule

// File: rtl/iack_arbiter.sv
module iack_arbiter
  import iarb_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int MOD_W = $clog2(N_MOD)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       id_wr_en,
  input  logic [MOD_W-1:0]           id_wr_sel,
  input  logic [ID_W-1:0]            id_wr_val,
  input  logic                       tmr_req,
  input  logic [LVL_W-1:0]           tmr_lvl,
  input  logic [LVL_W-1:0]           pin_lvl,
  input  logic [LVL_W-1:0]           edg_lvl,
  input  logic [LVL_W*(N_MOD-1)-1:0] peer_lvl,
  input  logic                       ack_start,
  input  logic [LVL_W-1:0]           ack_lvl,
  input  logic                       ack_done,
  output logic [N_MOD-1:0]           grant,
  output logic [N_LOC-1:0]           home_src,
  output logic                       no_taker,
  output logic                       cfg_err
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  arb_id_t          ids [N_MOD];
  logic             home_hit;
  logic [N_LOC-1:0] loc_sel;
  logic [N_MOD-1:0] contend;
  logic [N_MOD-1:0] win;
  logic             any;

  iarb_id_bank #(.N_MOD(N_MOD), .MOD_W(MOD_W)) u_ids (
    .clk     (clk),
    .rst_n   (rst_sync),
    .wr_en   (id_wr_en),
    .wr_sel  (id_wr_sel),
    .wr_id   (id_wr_val),
    .ids     (ids),
    .dup_err (cfg_err)
  );

  iarb_home_src u_home (
    .tmr_req  (tmr_req),
    .tmr_lvl  (tmr_lvl),
    .pin_lvl  (pin_lvl),
    .edg_lvl  (edg_lvl),
    .ack_lvl  (ack_lvl),
    .home_hit (home_hit),
    .loc_sel  (loc_sel)
  );

  assign contend[0] = (ids[0] != '0) && home_hit;
  for (genvar g = 1; g < N_MOD; g++) begin : g_peer
    lvl_t lvl;
    assign lvl        = peer_lvl[(g-1)*LVL_W +: LVL_W];
    assign contend[g] = (ids[g] != '0) && (lvl != '0) && (lvl == ack_lvl);
  end

  iarb_pick #(.N_MOD(N_MOD)) u_pick (
    .contend (contend),
    .ids     (ids),
    .win     (win),
    .any     (any)
  );

  // acknowledge cycle capture
  logic             busy_q, busy_d;
  logic [N_MOD-1:0] grant_q, grant_d;
  logic [N_LOC-1:0] src_q, src_d;
  logic             none_q, none_d;
  logic             cap_en, clr_en, upd_en;

  always_comb begin
    cap_en  = !busy_q && ack_start;
    clr_en  = busy_q && ack_done;
    upd_en  = cap_en || clr_en;
    busy_d  = 1'b0;
    grant_d = '0;
    src_d   = '0;
    none_d  = 1'b0;
    if (cap_en) begin
      busy_d  = 1'b1;
      grant_d = win;
      src_d   = win[0] ? loc_sel : '0;
      none_d  = !any;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
      src_q   <= '0;
      none_q  <= 1'b0;
    end else if (upd_en) begin
      busy_q  <= busy_d;
      grant_q <= grant_d;
      src_q   <= src_d;
      none_q  <= none_d;
    end
  end

  assign grant    = grant_q;
  assign home_src = src_q;
  assign no_taker = none_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0(grant_q)); // R5
  AST_NONE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_sync)
    none_q |-> grant_q == '0); // R8
  AST_SRC_NEEDS_HOME: assert property (@(posedge clk) disable iff (!rst_sync)
    (src_q != '0) |-> (grant_q[0] && $countones(src_q) == 1)); // R7
  AST_HOLD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync)
    (busy_q && !ack_done) |=> ($stable(grant_q) && $stable(src_q) && $stable(none_q))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync)
    !busy_q |-> (grant_q == '0 && !none_q)); // R10

endmodule

// File: tb/sim_iack_arbiter.sv
module sim_iack_arbiter;
  localparam int N_MOD = 4;
  localparam int MOD_W = 2;
  localparam int NV    = 13;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             id_wr_en;
  logic [MOD_W-1:0] id_wr_sel;
  logic [3:0]       id_wr_val;
  logic             tmr_req;
  logic [2:0]       tmr_lvl, pin_lvl, edg_lvl, ack_lvl;
  logic [8:0]       peer_lvl;
  logic             ack_start, ack_done;
  logic [3:0]       grant;
  logic [2:0]       home_src;
  logic             no_taker, cfg_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  iack_arbiter #(.N_MOD(N_MOD), .MOD_W(MOD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .id_wr_en(id_wr_en), .id_wr_sel(id_wr_sel),
    .id_wr_val(id_wr_val), .tmr_req(tmr_req), .tmr_lvl(tmr_lvl),
    .pin_lvl(pin_lvl), .edg_lvl(edg_lvl), .peer_lvl(peer_lvl),
    .ack_start(ack_start), .ack_lvl(ack_lvl), .ack_done(ack_done),
    .grant(grant), .home_src(home_src), .no_taker(no_taker), .cfg_err(cfg_err)
  );

  // {m3,m2,m1, treq,tlvl, pin,edg, ack, exp_grant, exp_src, exp_none}
  // IDs during the table: m0=8 m1=3 m2=C m3=5
  localparam logic [29:0] TBL [NV] = '{
    {3'd0,3'd0,3'd2, 1'b0,3'd0, 3'd0,3'd0, 3'd2, 4'b0010, 3'b000, 1'b0},
    {3'd2,3'd0,3'd2, 1'b0,3'd0, 3'd0,3'd0, 3'd2, 4'b1000, 3'b000, 1'b0},
    {3'd2,3'd2,3'd2, 1'b0,3'd0, 3'd0,3'd0, 3'd2, 4'b0100, 3'b000, 1'b0},
    {3'd0,3'd4,3'd2, 1'b0,3'd0, 3'd0,3'd0, 3'd2, 4'b0010, 3'b000, 1'b0},
    {3'd3,3'd0,3'd0, 1'b1,3'd3, 3'd0,3'd0, 3'd3, 4'b0001, 3'b001, 1'b0},
    {3'd0,3'd0,3'd0, 1'b1,3'd3, 3'd3,3'd3, 3'd3, 4'b0001, 3'b001, 1'b0},
    {3'd0,3'd0,3'd0, 1'b0,3'd0, 3'd3,3'd3, 3'd3, 4'b0001, 3'b010, 1'b0},
    {3'd0,3'd0,3'd0, 1'b0,3'd0, 3'd0,3'd3, 3'd3, 4'b0001, 3'b100, 1'b0},
    {3'd0,3'd0,3'd0, 1'b1,3'd0, 3'd0,3'd0, 3'd0, 4'b0000, 3'b000, 1'b1},
    {3'd0,3'd0,3'd0, 1'b0,3'd3, 3'd0,3'd0, 3'd3, 4'b0000, 3'b000, 1'b1},
    {3'd0,3'd6,3'd0, 1'b1,3'd6, 3'd0,3'd0, 3'd6, 4'b0100, 3'b000, 1'b0},
    {3'd4,3'd2,3'd1, 1'b0,3'd0, 3'd5,3'd0, 3'd7, 4'b0000, 3'b000, 1'b1},
    {3'd4,3'd0,3'd0, 1'b0,3'd0, 3'd3,3'd0, 3'd4, 4'b1000, 3'b000, 1'b0}
  };

  function automatic string tag(int i);
    case (i)
      0:       return "R2";
      1, 2:    return "R5";
      3, 12:   return "R3";
      4:       return "R5 R7";
      5, 6, 7: return "R7";
      8:       return "R6";
      9:       return "R8";
      10:      return "R5 R7";
      default: return "R3 R8";
    endcase
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic set_req(input logic [2:0] m3, input logic [2:0] m2, input logic [2:0] m1,
                         input logic tr, input logic [2:0] tl,
                         input logic [2:0] pl, input logic [2:0] el);
    @(negedge clk);
    peer_lvl = {m3, m2, m1};
    tmr_req  = tr;
    tmr_lvl  = tl;
    pin_lvl  = pl;
    edg_lvl  = el;
  endtask

  task automatic open_ack(input logic [2:0] lvl);
    @(negedge clk);
    ack_lvl   = lvl;
    ack_start = 1'b1;
    @(negedge clk);
    ack_start = 1'b0;
  endtask

  task automatic close_ack();
    ack_done = 1'b1;
    @(negedge clk);
    ack_done = 1'b0;
  endtask

  task automatic wr_id(input logic [1:0] sel, input logic [3:0] v);
    @(negedge clk);
    id_wr_en  = 1'b1;
    id_wr_sel = sel;
    id_wr_val = v;
    @(negedge clk);
    id_wr_en  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; id_wr_en = 1'b0; id_wr_sel = '0; id_wr_val = '0;
    tmr_req = 1'b0; tmr_lvl = '0; pin_lvl = '0; edg_lvl = '0; peer_lvl = '0;
    ack_start = 1'b0; ack_lvl = '0; ack_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 grant", 32'(grant), 32'h0);
    chk("R1 src", 32'(home_src), 32'h0);
    chk("R1 no_taker", 32'(no_taker), 32'h0);
    chk("R1 cfg_err", 32'(cfg_err), 32'h0);

    // R1 R4: peer IDs reset to zero, so a peer request finds no taker
    set_req(3'd0, 3'd0, 3'd2, 1'b0, 3'd0, 3'd0, 3'd0);
    open_ack(3'd2);
    chk("R1 R4 peer zero id", 32'(no_taker), 32'h1);
    close_ack();

    // R1: module 0 resets to ID F and wins alone
    set_req(3'd0, 3'd0, 3'd2, 1'b1, 3'd2, 3'd0, 3'd0);
    open_ack(3'd2);
    chk("R1 home grant", 32'(grant), 32'h1);
    chk("R1 home src", 32'(home_src), 32'h1);
    close_ack();

    // R11 program distinct IDs
    wr_id(2'd0, 4'h8);
    wr_id(2'd1, 4'h3);
    wr_id(2'd2, 4'hC);
    wr_id(2'd3, 4'h5);
    chk("R11 no dup", 32'(cfg_err), 32'h0);

    for (int i = 0; i < NV; i++) begin
      set_req(TBL[i][29:27], TBL[i][26:24], TBL[i][23:21], TBL[i][20],
              TBL[i][19:17], TBL[i][16:14], TBL[i][13:11]);
      open_ack(TBL[i][10:8]);
      chk(tag(i), 32'(grant), 32'(TBL[i][7:4]));
      chk(tag(i), 32'(home_src), 32'(TBL[i][3:1]));
      chk(tag(i), 32'(no_taker), 32'(TBL[i][0]));
      close_ack();
    end

    // R4: zero ID drops a pending module
    wr_id(2'd1, 4'h0);
    set_req(3'd0, 3'd0, 3'd2, 1'b0, 3'd0, 3'd0, 3'd0);
    open_ack(3'd2);
    chk("R4 zero id", 32'(no_taker), 32'h1);
    chk("R4 zero id grant", 32'(grant), 32'h0);
    close_ack();

    // R11: restore ID, module 1 wins again
    wr_id(2'd1, 4'h3);
    open_ack(3'd2);
    chk("R11 write back", 32'(grant), 32'h2);
    close_ack();

    // R9: duplicate non-zero IDs
    wr_id(2'd3, 4'hC);
    chk("R9 dup flag", 32'(cfg_err), 32'h1);
    set_req(3'd4, 3'd4, 3'd0, 1'b0, 3'd0, 3'd0, 3'd0);
    open_ack(3'd4);
    chk("R9 tie grant", 32'(grant), 32'h4);
    close_ack();
    wr_id(2'd3, 4'h5);
    chk("R9 dup cleared", 32'(cfg_err), 32'h0);
    wr_id(2'd1, 4'h0);
    wr_id(2'd2, 4'h0);
    chk("R9 zero dup ok", 32'(cfg_err), 32'h0);
    wr_id(2'd1, 4'h3);
    wr_id(2'd2, 4'hC);

    // R10: hold through the cycle
    set_req(3'd0, 3'd0, 3'd2, 1'b0, 3'd0, 3'd0, 3'd0);
    open_ack(3'd2);
    chk("R10 captured", 32'(grant), 32'h2);
    peer_lvl = {3'd2, 3'd2, 3'd2};
    tmr_req = 1'b1; tmr_lvl = 3'd5;
    open_ack(3'd5);
    chk("R10 held grant", 32'(grant), 32'h2);
    chk("R10 held src", 32'(home_src), 32'h0);
    close_ack();
    chk("R10 cleared", 32'(grant), 32'h0);
    chk("R10 cleared none", 32'(no_taker), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule